// File: doc/BRIEF.md
# Abstract Command Controller

This block is the front end that a debug module uses to launch register-access commands on a hart. A debugger reaches it through a simple register port: one command word, one status word, one auto-execute mask word, a small bank of data words and a small bank of program words. When a valid command arrives and the selected hart is halted, the controller raises a per-hart "go" flag and marks itself busy. The hart side reports back with three single-cycle notifications: going (the hart has taken the go flag), halted (the hart is parked again) and exception (the command faulted).

Faults are recorded in a sticky three-bit error code. The code stays until the debugger writes ones to the bits it wants cleared, and no command is started while a code is pending. Once a command has been stored, each data or program word can be set up to re-run it on every access. This lets a debugger stream a block of values with one register access per value.

Top module: `abs_cmd_ctrl`

## Requirements
- R1: While the error code is non-zero, a command write or auto-execute trigger starts nothing: busy and go stay low and the code is unchanged.
- R2: A command write while busy sets the error code to 1 (busy), provided the code was 0.
- R3: The error code is sticky. A write to the status word (0x10) clears exactly the code bits (status bits 10:8) written as 1.
- R4: A command whose type field (bits 31:24) is non-zero sets the error code to 2 (not supported).
- R5: A command of type 0 to a hart not reported halted on hart_halted_i sets the error code to 4 (halt/resume).
- R6: A type-0 command to a halted hart whose size field (bits 22:20) is neither 2 nor 3 sets the error code to 2.
- R7: An accepted command sets busy (status bit 12) and the go bit of the selected hart. going_ev_i clears the selected hart's go bit. busy clears on halted_ev_i only when halted_id_i equals hartsel_i and that hart's go bit is already clear.
- R8: exc_ev_i sets the error code to 3 (exception) only when the code was 0.
- R9: While busy, reads of data words (0x00+i) and program words (0x20+i) return all ones and writes to them are dropped. A data-word access while busy also sets the code to 1 if it was 0; a program-word access does not touch the code.
- R10: When not busy, a read or write of data word i re-runs the stored command if bit i of the auto word (0x12) is set. The same holds for program word i with bit 16+i. The auto word reads back as written.
- R11: The command word (0x11) reads as 0. The status word carries DATA_CNT in bits 3:0 and PB_CNT in bits 28:24; all other bits outside busy and the error code read as 0.
- R12: When not busy, data and program words store what is written and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of req_i |
| hartsel_i | input | HS_W | Selected hart |
| hart_halted_i | input | NHARTS | Per-hart halted state |
| halted_ev_i | input | 1 | Hart reports it is parked |
| halted_id_i | input | HS_W | Hart sending the halted notification |
| going_ev_i | input | 1 | Selected hart took its go flag |
| exc_ev_i | input | 1 | Command raised an exception |
| go_o | output | NHARTS | Per-hart go flags |

## Verification
Commands are issued with each fault in turn: a wrong type, a running hart, an illegal size, a pending error and an overlap with busy. Each should leave a different error code, or none, in the status word. Accepted commands are finished with notifications in several orders: halted while go is still set, halted from the wrong hart, then going and halted. This separates a correct busy release from an early one. Auto-execute is tried on a data word by write and by read, on an unmasked data word, and on a program word with the second hart selected. These cases show that the mask and the go flag follow the right index.

// File: rtl/abs_cmd_pkg.sv
package abs_cmd_pkg;
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BUSY   = 3'd1,
    ERR_NOTSUP = 3'd2,
    ERR_EXC    = 3'd3,
    ERR_HALT   = 3'd4
  } cmd_err_e;

  localparam int unsigned ADDR_W      = 6;
  localparam logic [ADDR_W-1:0] A_STATUS  = 6'h10;
  localparam logic [ADDR_W-1:0] A_CMD     = 6'h11;
  localparam logic [ADDR_W-1:0] A_AUTO    = 6'h12;
  localparam logic [ADDR_W-1:0] A_DATA    = 6'h00;
  localparam logic [ADDR_W-1:0] A_PBUF    = 6'h20;
  localparam int unsigned AUTO_PB_LSB = 16;
endpackage

// File: rtl/abs_cmd_check.sv
module abs_cmd_check
  import abs_cmd_pkg::*;
(
  input  logic [7:0] type_i,
  input  logic [2:0] size_i,
  input  logic       err_pend_i,
  input  logic       busy_i,
  input  logic       halted_i,
  output logic       launch_o,
  output logic       fail_o,
  output cmd_err_e   code_o
);
  always_comb begin
    launch_o = 1'b0;
    fail_o   = 1'b1;
    code_o   = ERR_NONE;
    if (err_pend_i) begin
      fail_o = 1'b0;
    end else if (busy_i) begin
      code_o = ERR_BUSY;
    end else if (type_i != 8'd0) begin
      code_o = ERR_NOTSUP;
    end else if (!halted_i) begin
      code_o = ERR_HALT;
    end else if (size_i != 3'd2 && size_i != 3'd3) begin
      code_o = ERR_NOTSUP;
    end else begin
      fail_o   = 1'b0;
      launch_o = 1'b1;
    end
  end
endmodule

// File: rtl/abs_cmd_err.sv
module abs_cmd_err
  import abs_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_en_i,
  input  logic [2:0] clr_mask_i,
  input  logic       set_en_i,
  input  cmd_err_e   set_code_i,
  input  logic       exc_i,
  output cmd_err_e   err_o
);
  cmd_err_e err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (err_q == ERR_NONE) begin
      if (set_en_i)   err_d = set_code_i;   // command fault wins over exception
      else if (exc_i) err_d = ERR_EXC;
    end else if (clr_en_i) begin
      err_d = cmd_err_e'(err_q & ~clr_mask_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= ERR_NONE;
    else         err_q <= err_d;
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ERR_NONE && !clr_en_i) |=> (err_q == $past(err_q))); // R3
  AST_EXC_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i && err_q == ERR_NONE) |=> (err_q != ERR_NONE)); // R8
endmodule

// File: rtl/abs_cmd_bank.sv
module abs_cmd_bank #(
  parameter int unsigned WORDS = 2,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[w] <= '0;
      else if (wr_en_i && idx_i == IDX_W'(w))        mem_q[w] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/abs_cmd_ctrl.sv
module abs_cmd_ctrl
  import abs_cmd_pkg::*;
#(
  parameter int unsigned DATA_CNT = 2,
  parameter int unsigned PB_CNT   = 4,
  parameter int unsigned NHARTS   = 2,
  localparam int unsigned HS_W    = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [5:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [HS_W-1:0]   hartsel_i,
  input  logic [NHARTS-1:0] hart_halted_i,
  input  logic              halted_ev_i,
  input  logic [HS_W-1:0]   halted_id_i,
  input  logic              going_ev_i,
  input  logic              exc_ev_i,
  output logic [NHARTS-1:0] go_o
);
  localparam int unsigned DIDX_W = (DATA_CNT > 1) ? $clog2(DATA_CNT) : 1;
  localparam int unsigned PIDX_W = (PB_CNT > 1) ? $clog2(PB_CNT) : 1;

  // address decode
  logic data_hit, pbuf_hit, cmd_wr, stat_wr, auto_wr;
  logic [DIDX_W-1:0] didx;
  logic [PIDX_W-1:0] pidx;

  assign data_hit = req_i && (addr_i >= A_DATA) && (addr_i < A_DATA + ADDR_W'(DATA_CNT));
  assign pbuf_hit = req_i && (addr_i >= A_PBUF) && (addr_i < A_PBUF + ADDR_W'(PB_CNT));
  assign cmd_wr   = req_i && we_i && (addr_i == A_CMD);
  assign stat_wr  = req_i && we_i && (addr_i == A_STATUS);
  assign auto_wr  = req_i && we_i && (addr_i == A_AUTO);
  assign didx     = DIDX_W'(addr_i - A_DATA);
  assign pidx     = PIDX_W'(addr_i - A_PBUF);

  // state
  logic                busy_q;
  logic [NHARTS-1:0]   go_q;
  logic [7:0]          cmd_type_q;
  logic [2:0]          cmd_size_q;
  logic [DATA_CNT-1:0] auto_data_q;
  logic [PB_CNT-1:0]   auto_pb_q;
  cmd_err_e            err_q;

  // hart selection
  logic [NHARTS-1:0] hsel_oh;
  for (genvar h = 0; h < NHARTS; h++) begin : g_hsel
    assign hsel_oh[h] = (hartsel_i == HS_W'(h));
  end
  logic sel_halted, sel_go, halt_from_sel;
  assign sel_halted    = |(hart_halted_i & hsel_oh);
  assign sel_go        = |(go_q & hsel_oh);
  assign halt_from_sel = halted_ev_i && (halted_id_i == hartsel_i);

  // execution request: direct write or auto trigger
  logic auto_trig, exec_req;
  assign auto_trig = !busy_q && ((data_hit && auto_data_q[didx]) ||
                                 (pbuf_hit && auto_pb_q[pidx]));
  assign exec_req  = cmd_wr || auto_trig;

  logic [7:0] chk_type;
  logic [2:0] chk_size;
  assign chk_type = cmd_wr ? wdata_i[31:24] : cmd_type_q;
  assign chk_size = cmd_wr ? wdata_i[22:20] : cmd_size_q;

  logic     chk_launch, chk_fail;
  cmd_err_e chk_code;

  abs_cmd_check u_check (
    .type_i    (chk_type),
    .size_i    (chk_size),
    .err_pend_i(err_q != ERR_NONE),
    .busy_i    (busy_q),
    .halted_i  (sel_halted),
    .launch_o  (chk_launch),
    .fail_o    (chk_fail),
    .code_o    (chk_code)
  );

  logic launch, data_busy_hit, err_set;
  cmd_err_e err_code;
  assign launch        = exec_req && chk_launch;
  assign data_busy_hit = data_hit && busy_q;
  assign err_set       = (exec_req && chk_fail) || data_busy_hit;
  assign err_code      = data_busy_hit ? ERR_BUSY : chk_code;

  abs_cmd_err u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_en_i  (stat_wr),
    .clr_mask_i(wdata_i[10:8]),
    .set_en_i  (err_set),
    .set_code_i(err_code),
    .exc_i     (exc_ev_i),
    .err_o     (err_q)
  );

  // busy and command storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cmd_type_q  <= '0;
      cmd_size_q  <= '0;
      auto_data_q <= '0;
      auto_pb_q   <= '0;
    end else begin
      if (launch)                         busy_q <= 1'b1;
      else if (halt_from_sel && !sel_go)  busy_q <= 1'b0;
      if (cmd_wr) begin
        cmd_type_q <= wdata_i[31:24];
        cmd_size_q <= wdata_i[22:20];
      end
      if (auto_wr) begin
        auto_data_q <= wdata_i[DATA_CNT-1:0];
        auto_pb_q   <= wdata_i[AUTO_PB_LSB +: PB_CNT];
      end
    end
  end

  for (genvar h = 0; h < NHARTS; h++) begin : g_go
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       go_q[h] <= 1'b0;
      else if (launch && hsel_oh[h])     go_q[h] <= 1'b1;
      else if (going_ev_i && hsel_oh[h]) go_q[h] <= 1'b0;
    end
  end
  assign go_o = go_q;

  // word banks
  logic [31:0] data_rd, pbuf_rd;

  abs_cmd_bank #(.WORDS(DATA_CNT), .DW(32)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(data_hit && we_i && !busy_q),
    .idx_i  (didx),
    .wdata_i(wdata_i),
    .rdata_o(data_rd)
  );

  abs_cmd_bank #(.WORDS(PB_CNT), .DW(32)) u_pbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(pbuf_hit && we_i && !busy_q),
    .idx_i  (pidx),
    .wdata_i(wdata_i),
    .rdata_o(pbuf_rd)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    if (data_hit) begin
      rdata_o = busy_q ? '1 : data_rd;
    end else if (pbuf_hit) begin
      rdata_o = busy_q ? '1 : pbuf_rd;
    end else if (addr_i == A_STATUS) begin
      rdata_o[3:0]   = 4'(DATA_CNT);
      rdata_o[10:8]  = err_q;
      rdata_o[12]    = busy_q;
      rdata_o[28:24] = 5'(PB_CNT);
    end else if (addr_i == A_AUTO) begin
      rdata_o[DATA_CNT-1:0]            = auto_data_q;
      rdata_o[AUTO_PB_LSB +: PB_CNT]   = auto_pb_q;
    end
  end

  AST_NO_LAUNCH_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ERR_NONE && !busy_q) |=> !busy_q); // R1
  AST_BUSY_FALL_NEEDS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(halted_ev_i)); // R7
  AST_LAUNCH_RAISES_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (go_q != '0)); // R7
endmodule

// File: tb/tb_abs_cmd_ctrl.sv
module tb_abs_cmd_ctrl;
  localparam logic [5:0] STAT = 6'h10, CMD = 6'h11, AUTO = 6'h12;
  localparam logic [31:0] S = 32'h0400_0002;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [0:0] hartsel = '0, halted_id = '0;
  logic [1:0] hart_halted = '0, go;
  logic halted_ev = 0, going_ev = 0, exc_ev = 0;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  abs_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hartsel_i(hartsel),
    .hart_halted_i(hart_halted), .halted_ev_i(halted_ev),
    .halted_id_i(halted_id), .going_ev_i(going_ev), .exc_ev_i(exc_ev),
    .go_o(go)
  );

  // monitor: pops an expected item for every read it sees
  always @(negedge clk) begin
    if (req && !we) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic drive(input bit w, input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    drive(1'b1, a, d);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    drive(1'b0, a, '0);
  endtask

  task automatic chk_go(input logic [1:0] e, input string t);
    @(negedge clk);
    n_cmp++;
    if (go !== e) begin
      n_bad++;
      $display("FAIL %s: actual go %b expected %b", t, go, e);
    end
  endtask

  task automatic pulse_halted(input logic [0:0] id);
    @(posedge clk); #1; halted_ev = 1; halted_id = id;
    @(posedge clk); #1; halted_ev = 0;
  endtask

  task automatic pulse_going();
    @(posedge clk); #1; going_ev = 1;
    @(posedge clk); #1; going_ev = 0;
  endtask

  task automatic pulse_exc();
    @(posedge clk); #1; exc_ev = 1;
    @(posedge clk); #1; exc_ev = 0;
  endtask

  task automatic finish_cmd(input logic [0:0] id);
    pulse_going();
    pulse_halted(id);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;

    rd(STAT, S, "R11 reset status fields");
    chk_go(2'b00, "R7 reset go");

    wr(6'h00, 32'h1111_1111);
    rd(6'h00, 32'h1111_1111, "R12 data0 readback");
    wr(6'h22, 32'h0000_A5A5);
    rd(6'h22, 32'h0000_A5A5, "R12 pbuf2 readback");

    wr(CMD, 32'h0100_0000);
    rd(STAT, S | 32'h200, "R4 bad type");
    rd(CMD, 32'h0, "R11 command reads zero");

    hart_halted = 2'b01;
    wr(CMD, 32'h0020_0000);
    rd(STAT, S | 32'h200, "R1 blocked by pending error");
    chk_go(2'b00, "R1 no go while error");

    wr(STAT, 32'h100);
    rd(STAT, S | 32'h200, "R3 partial clear");
    wr(STAT, 32'h200);
    rd(STAT, S, "R3 clear");

    hart_halted = 2'b00;
    wr(CMD, 32'h0020_0000);
    rd(STAT, S | 32'h400, "R5 hart running");
    wr(STAT, 32'h700);

    hart_halted = 2'b01;
    wr(CMD, 32'h0010_0000);
    rd(STAT, S | 32'h200, "R6 size 1");
    wr(STAT, 32'h700);
    wr(CMD, 32'h0040_0000);
    rd(STAT, S | 32'h200, "R6 size 4");
    wr(STAT, 32'h700);

    wr(CMD, 32'h0030_0000);
    rd(STAT, S | 32'h1000, "R7 accepted");
    chk_go(2'b01, "R7 go raised");

    wr(CMD, 32'h0030_0000);
    rd(STAT, S | 32'h1100, "R2 command while busy");
    wr(STAT, 32'h700);
    rd(STAT, S | 32'h1000, "R3 clear while busy");

    rd(6'h22, 32'hFFFF_FFFF, "R9 pbuf read busy");
    rd(STAT, S | 32'h1000, "R9 pbuf no error");
    wr(6'h20, 32'h0000_DEAD);
    rd(6'h00, 32'hFFFF_FFFF, "R9 data read busy");
    rd(STAT, S | 32'h1100, "R9 data sets busy error");
    wr(STAT, 32'h700);
    wr(6'h01, 32'h0000_0077);
    rd(STAT, S | 32'h1100, "R9 data write sets busy error");
    wr(STAT, 32'h700);

    pulse_halted(1'b0);
    rd(STAT, S | 32'h1000, "R7 halted with go set");
    pulse_going();
    chk_go(2'b00, "R7 going clears go");
    pulse_halted(1'b1);
    rd(STAT, S | 32'h1000, "R7 halted from other hart");
    pulse_halted(1'b0);
    rd(STAT, S, "R7 busy released");

    rd(6'h01, 32'h0, "R9 dropped data write");
    rd(6'h20, 32'h0, "R9 dropped pbuf write");
    rd(6'h00, 32'h1111_1111, "R12 data0 kept");

    pulse_exc();
    rd(STAT, S | 32'h300, "R8 exception");
    wr(STAT, 32'h700);
    wr(CMD, 32'h0100_0000);
    pulse_exc();
    rd(STAT, S | 32'h200, "R8 exception not over prior code");
    wr(STAT, 32'h700);

    wr(AUTO, 32'h0000_0002);
    rd(AUTO, 32'h0000_0002, "R10 auto readback");
    wr(CMD, 32'h0020_0000);
    finish_cmd(1'b0);
    rd(STAT, S, "R10 idle before auto");
    wr(6'h01, 32'h0000_0033);
    rd(STAT, S | 32'h1000, "R10 auto on data write");
    chk_go(2'b01, "R10 go on auto");
    finish_cmd(1'b0);
    rd(6'h01, 32'h0000_0033, "R10 read triggers, returns data");
    rd(STAT, S | 32'h1000, "R10 auto on data read");
    finish_cmd(1'b0);
    rd(6'h00, 32'h1111_1111, "R10 unmasked word");
    rd(STAT, S, "R10 no trigger unmasked");

    wr(AUTO, 32'h0008_0000);
    hartsel = 1'b1;
    hart_halted = 2'b10;
    wr(6'h23, 32'h0000_0055);
    rd(STAT, S | 32'h1000, "R10 auto on pbuf3");
    chk_go(2'b10, "R7 go on hart1");
    finish_cmd(1'b1);
    chk_go(2'b00, "R7 hart1 go cleared");
    rd(STAT, S, "R7 hart1 released");

    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule